// File: doc/BRIEF.md
# Segment Descriptor Translation Cache

This block keeps a handful of recently used segment descriptors and turns a logical reference (segment number plus displacement) into a physical address. A lookup is compared against every cached segment number at once. When a slot matches, the block checks that the segment is resident, that the displacement lies inside the segment, and that the requested kind of access is allowed. If all three hold, it returns the base plus the displacement. Otherwise it reports a fault or a violation and gives no address.

When no slot matches, the block stalls new lookups and raises a refill request that names the missing segment. An outside agent fetches the descriptor and presents it on the fill port. The block writes it into a slot and replays the held lookup. If any slot is empty, the lowest-numbered empty slot is used. If none is empty, a second-chance sweep picks a slot that has not been referenced recently. Two saturating counters record accepted lookups and first-try matches, so software can compute the hit ratio.

Top module: `seg_xlate_cache`

## Requirements
- R1: A lookup accepted while `req_ready` is high that matches a resident slot, with displacement below the length and an allowed access, gives `resp_valid` one cycle after acceptance. It carries `resp_code` 0 and `resp_phys` = base + displacement.
- R2: A match whose displacement is equal to or greater than the slot's length responds with `resp_code` 1 and `resp_phys` 0.
- R3: Access bits are {execute, write, read} at positions 2, 1, 0. A match that requests any bit absent from the slot's rights responds with `resp_code` 1 and `resp_phys` 0.
- R4: A match on a slot whose presence flag is clear responds with `resp_code` 2 and `resp_phys` 0. This takes priority over R2 and R3.
- R5: A lookup that matches no valid slot produces no response. From the next cycle, `miss_req` is high, `miss_seg` holds the requested segment and `req_ready` is low, until the refill is taken.
- R6: A fill presented while `miss_req` is high is written into a slot. The held lookup is replayed, and its response appears two cycles after the fill cycle.
- R7: While any slot is invalid, a fill goes to the lowest-numbered invalid slot, and no valid slot is evicted.
- R8: When all slots are valid, the victim is the first slot at or after the sweep pointer whose reference flag is clear. Flags passed on the way are cleared. The pointer moves to the slot after the victim. If every flag is set, all flags are cleared and the slot at the pointer is taken. A matching lookup or replay sets that slot's flag.
- R9: A one-cycle `flush` pulse invalidates every slot, so the next lookup of any segment misses.
- R10: `lookup_cnt` increments for each accepted lookup. `hit_cnt` increments for each accepted lookup that matches on the first try. Replays change neither counter.
- R11: Both counters stop at their all-ones value instead of wrapping.
- R12: A `cnt_clr` pulse sets both counters to zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a lookup |
| req_seg | input | SEG_W | Segment number of the lookup |
| req_disp | input | DISP_W | Displacement within the segment |
| req_acc | input | 3 | Requested access {exec, write, read} |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 2 | 0 ok, 1 violation, 2 segment fault |
| resp_phys | output | PHYS_W | Physical address, zero unless ok |
| miss_req | output | 1 | Refill wanted |
| miss_seg | output | SEG_W | Segment to refill |
| fill_valid | input | 1 | Refill descriptor present |
| fill_base | input | PHYS_W | Base of the segment |
| fill_len | input | DISP_W+1 | Segment length |
| fill_rights | input | 3 | Allowed access {exec, write, read} |
| fill_present | input | 1 | Segment is resident |
| flush | input | 1 | Invalidate all slots |
| cnt_clr | input | 1 | Clear both counters |
| lookup_cnt | output | CNT_W | Accepted lookups, saturating |
| hit_cnt | output | CNT_W | First-try matches, saturating |

## Verification
Replacement is the hardest behaviour to reach. It is observable only after the cache is full, and the reference flags and sweep pointer are visible only through later misses. The stimulus fills all four slots, then alternates misses with hits on chosen segments. This sets up one sweep that clears every flag, one that takes the slot at the pointer, and one that passes a referenced slot. Each eviction is then confirmed by checking which segments hit and which miss afterwards.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [1:0] {
    SX_IDLE   = 2'd0,
    SX_WAIT   = 2'd1,
    SX_REPLAY = 2'd2
  } segx_state_e;

  localparam logic [1:0] RSP_OK    = 2'd0;
  localparam logic [1:0] RSP_VIOL  = 2'd1;
  localparam logic [1:0] RSP_FAULT = 2'd2;
  localparam int         ACC_W     = 3;
endpackage

// File: rtl/segx_match.sv
module segx_match #(
  parameter int N     = 4,
  parameter int SEG_W = 6,
  parameter int IDX_W = 2
) (
  input  logic [SEG_W-1:0]        key,
  input  logic [N-1:0][SEG_W-1:0] tags,
  input  logic [N-1:0]            valid,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] hv;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hv[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hv[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |hv;
endmodule

// File: rtl/segx_victim.sv
module segx_victim #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     refb,
  input  logic [IDX_W-1:0] hand,
  output logic [IDX_W-1:0] vic,
  output logic [N-1:0]     pass_clr,
  output logic [IDX_W-1:0] hand_nx
);
  logic             use_inv;
  logic [IDX_W-1:0] inv_idx;
  logic             found;
  logic [IDX_W-1:0] sweep_idx;
  logic [IDX_W-1:0] pos;
  logic [N-1:0]     sweep_clr;

  always_comb begin
    use_inv = 1'b0;
    inv_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        use_inv = 1'b1;
        inv_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    found     = 1'b0;
    sweep_idx = hand;
    sweep_clr = '0;
    pos       = hand;
    for (int k = 0; k < N; k++) begin
      pos = IDX_W'(hand + IDX_W'(k));
      if (!found) begin
        if (!refb[pos]) begin
          found     = 1'b1;
          sweep_idx = pos;
        end else begin
          sweep_clr[pos] = 1'b1;
        end
      end
    end
  end

  assign vic      = use_inv ? inv_idx : sweep_idx;
  assign pass_clr = use_inv ? '0 : sweep_clr;
  assign hand_nx  = use_inv ? hand : IDX_W'(sweep_idx + 1'b1);
endmodule

// File: rtl/segx_satcnt.sv
module segx_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && (cnt != {W{1'b1}}));
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/seg_xlate_cache.sv
module seg_xlate_cache
  import segx_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int SEG_W   = 6,
  parameter int DISP_W  = 12,
  parameter int PHYS_W  = 16,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [2:0]        req_acc,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic [PHYS_W-1:0] resp_phys,
  output logic              miss_req,
  output logic [SEG_W-1:0]  miss_seg,
  input  logic              fill_valid,
  input  logic [PHYS_W-1:0] fill_base,
  input  logic [DISP_W:0]   fill_len,
  input  logic [2:0]        fill_rights,
  input  logic              fill_present,
  input  logic              flush,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  lookup_cnt,
  output logic [CNT_W-1:0]  hit_cnt
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LEN_W = DISP_W + 1;

  segx_state_e st_q, st_d;

  logic [ENTRIES-1:0][SEG_W-1:0]  tag_q,  tag_d;
  logic [ENTRIES-1:0][PHYS_W-1:0] base_q, base_d;
  logic [ENTRIES-1:0][LEN_W-1:0]  len_q,  len_d;
  logic [ENTRIES-1:0][ACC_W-1:0]  rgt_q,  rgt_d;
  logic [ENTRIES-1:0]             pres_q, pres_d;
  logic [ENTRIES-1:0]             vld_q,  vld_d;
  logic [ENTRIES-1:0]             refb_q, refb_d;
  logic [IDX_W-1:0]               hand_q, hand_d;

  logic [SEG_W-1:0]  pend_seg_q;
  logic [DISP_W-1:0] pend_disp_q;
  logic [2:0]        pend_acc_q;

  logic              rsp_v_d;
  logic [1:0]        rsp_code_d;
  logic [PHYS_W-1:0] rsp_phys_d;

  logic              accept, look_act, fill_we;
  logic [SEG_W-1:0]  look_seg;
  logic [DISP_W-1:0] look_disp;
  logic [2:0]        look_acc;
  logic              m_hit;
  logic [IDX_W-1:0]  m_idx;
  logic [IDX_W-1:0]  vic, vic_hand_nx;
  logic [ENTRIES-1:0] pass_clr;

  assign accept    = (st_q == SX_IDLE) && req_valid;
  assign look_act  = accept || (st_q == SX_REPLAY);
  assign fill_we   = (st_q == SX_WAIT) && fill_valid && !flush;
  assign look_seg  = (st_q == SX_REPLAY) ? pend_seg_q  : req_seg;
  assign look_disp = (st_q == SX_REPLAY) ? pend_disp_q : req_disp;
  assign look_acc  = (st_q == SX_REPLAY) ? pend_acc_q  : req_acc;

  segx_match #(.N(ENTRIES), .SEG_W(SEG_W), .IDX_W(IDX_W)) u_match (
    .key(look_seg), .tags(tag_q), .valid(vld_q), .hit(m_hit), .idx(m_idx)
  );

  segx_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid(vld_q), .refb(refb_q), .hand(hand_q),
    .vic(vic), .pass_clr(pass_clr), .hand_nx(vic_hand_nx)
  );

  segx_satcnt #(.W(CNT_W)) u_cnt_look (
    .clk(clk), .rst_n(rst_n), .inc(accept), .clr(cnt_clr), .cnt(lookup_cnt)
  );

  segx_satcnt #(.W(CNT_W)) u_cnt_hit (
    .clk(clk), .rst_n(rst_n), .inc(accept && m_hit), .clr(cnt_clr), .cnt(hit_cnt)
  );

  // response and sequencing
  always_comb begin
    rsp_v_d    = look_act && m_hit;
    rsp_code_d = RSP_OK;
    rsp_phys_d = '0;
    if (!pres_q[m_idx]) begin
      rsp_code_d = RSP_FAULT;
    end else if (({1'b0, look_disp} >= len_q[m_idx]) ||
                 ((look_acc & ~rgt_q[m_idx]) != 3'b000)) begin
      rsp_code_d = RSP_VIOL;
    end else begin
      rsp_phys_d = base_q[m_idx] + PHYS_W'(look_disp);
    end

    st_d = st_q;
    unique case (st_q)
      SX_IDLE:   if (accept && !m_hit) st_d = SX_WAIT;
      SX_WAIT:   if (fill_valid)       st_d = SX_REPLAY;
      SX_REPLAY: st_d = m_hit ? SX_IDLE : SX_WAIT;
      default:   st_d = SX_IDLE;
    endcase
  end

  // slot storage and replacement state
  always_comb begin
    tag_d  = tag_q;
    base_d = base_q;
    len_d  = len_q;
    rgt_d  = rgt_q;
    pres_d = pres_q;
    vld_d  = vld_q;
    refb_d = refb_q;
    hand_d = hand_q;
    if (flush) begin
      vld_d  = '0;
      refb_d = '0;
    end else if (fill_we) begin
      tag_d[vic]  = pend_seg_q;
      base_d[vic] = fill_base;
      len_d[vic]  = fill_len;
      rgt_d[vic]  = fill_rights;
      pres_d[vic] = fill_present;
      vld_d[vic]  = 1'b1;
      refb_d      = refb_q & ~pass_clr;
      refb_d[vic] = 1'b0;
      hand_d      = vic_hand_nx;
    end else if (look_act && m_hit) begin
      refb_d[m_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SX_IDLE;
      tag_q      <= '0;
      base_q     <= '0;
      len_q      <= '0;
      rgt_q      <= '0;
      pres_q     <= '0;
      vld_q      <= '0;
      refb_q     <= '0;
      hand_q     <= '0;
      resp_valid <= 1'b0;
      resp_code  <= RSP_OK;
      resp_phys  <= '0;
    end else begin
      st_q       <= st_d;
      tag_q      <= tag_d;
      base_q     <= base_d;
      len_q      <= len_d;
      rgt_q      <= rgt_d;
      pres_q     <= pres_d;
      vld_q      <= vld_d;
      refb_q     <= refb_d;
      hand_q     <= hand_d;
      resp_valid <= rsp_v_d;
      resp_code  <= rsp_code_d;
      resp_phys  <= rsp_phys_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_seg_q  <= '0;
      pend_disp_q <= '0;
      pend_acc_q  <= '0;
    end else if (accept) begin
      pend_seg_q  <= req_seg;
      pend_disp_q <= req_disp;
      pend_acc_q  <= req_acc;
    end
  end

  assign req_ready = (st_q == SX_IDLE);
  assign miss_req  = (st_q == SX_WAIT);
  assign miss_seg  = pend_seg_q;
endmodule

// File: rtl/segx_xlate_chk.sv
module segx_xlate_chk #(
  parameter int SEG_W  = 6,
  parameter int PHYS_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic [1:0]        resp_code,
  input logic [PHYS_W-1:0] resp_phys,
  input logic              miss_req,
  input logic [SEG_W-1:0]  miss_seg,
  input logic              fill_valid,
  input logic              flush,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  lookup_cnt,
  input logic [CNT_W-1:0]  hit_cnt
);
  // R2 R3 R4: a refused reference never carries an address
  p_no_addr_on_refusal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code != 2'd0) |-> (resp_phys == '0));

  // R4: only the three defined codes appear
  p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_code != 2'd3));

  // R5: stall while a refill is outstanding
  p_miss_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> !req_ready);

  // R5: the requested segment holds while waiting
  p_miss_seg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && $past(miss_req)) |-> $stable(miss_seg));

  // R6: a fill taken during a miss leads to a response two cycles later
  p_fill_replays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && fill_valid && !flush) |=> ##1 resp_valid);

  // R10 R11: counters never step back nor jump, except on clear
  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr) |-> ((lookup_cnt == $past(lookup_cnt)) ||
                         (lookup_cnt == $past(lookup_cnt) + 1'b1)));

  // R10: first-try matches never exceed lookups
  p_hits_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt <= lookup_cnt);

  // R12: clear empties both counters
  p_clear_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_clr) |-> (lookup_cnt == '0 && hit_cnt == '0));
endmodule

bind seg_xlate_cache segx_xlate_chk #(
  .SEG_W(SEG_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_code(resp_code), .resp_phys(resp_phys), .miss_req(miss_req),
  .miss_seg(miss_seg), .fill_valid(fill_valid), .flush(flush),
  .cnt_clr(cnt_clr), .lookup_cnt(lookup_cnt), .hit_cnt(hit_cnt)
);

// File: tb/test_seg_xlate_cache.sv
module test_seg_xlate_cache;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W  = 6;
  localparam int DISP_W = 12;
  localparam int PHYS_W = 16;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [SEG_W-1:0]  req_seg;
  logic [DISP_W-1:0] req_disp;
  logic [2:0]        req_acc;
  logic              resp_valid;
  logic [1:0]        resp_code;
  logic [PHYS_W-1:0] resp_phys;
  logic              miss_req;
  logic [SEG_W-1:0]  miss_seg;
  logic              fill_valid;
  logic [PHYS_W-1:0] fill_base;
  logic [DISP_W:0]   fill_len;
  logic [2:0]        fill_rights;
  logic              fill_present;
  logic              flush;
  logic              cnt_clr;
  logic [CNT_W-1:0]  lookup_cnt;
  logic [CNT_W-1:0]  hit_cnt;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0]        code;
    logic [PHYS_W-1:0] phys;
    string             req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_cache #(
    .ENTRIES(4), .SEG_W(SEG_W), .DISP_W(DISP_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W)
  ) i_seg_xlate_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_disp(req_disp), .req_acc(req_acc),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_phys(resp_phys),
    .miss_req(miss_req), .miss_seg(miss_seg), .fill_valid(fill_valid),
    .fill_base(fill_base), .fill_len(fill_len), .fill_rights(fill_rights),
    .fill_present(fill_present), .flush(flush), .cnt_clr(cnt_clr),
    .lookup_cnt(lookup_cnt), .hit_cnt(hit_cnt)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected responses in order
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && resp_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected response: actual=%0h expected=none", resp_phys);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, "resp_code", 32'(resp_code), 32'(e.code));
          chk(e.req, "resp_phys", 32'(resp_phys), 32'(e.phys));
        end
      end
    end
  end

  task automatic push(logic [1:0] code, logic [PHYS_W-1:0] phys, string req);
    exp_t e;
    e.code = code; e.phys = phys; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic look_hit(logic [SEG_W-1:0] s, logic [DISP_W-1:0] d, logic [2:0] a,
                          logic [1:0] ecode, logic [PHYS_W-1:0] ephys, string req);
    push(ecode, ephys, req);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_disp = d; req_acc = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "response one cycle after accept", 32'(resp_valid), 32'd1);
  endtask

  task automatic look_miss(logic [SEG_W-1:0] s, logic [DISP_W-1:0] d, logic [2:0] a,
                           logic [PHYS_W-1:0] b, logic [DISP_W:0] l, logic [2:0] r,
                           logic p, logic [1:0] ecode, logic [PHYS_W-1:0] ephys,
                           string req);
    push(ecode, ephys, req);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_disp = d; req_acc = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({"R5 ", req}, "no response on miss", 32'(resp_valid), 32'd0);
    chk({"R5 ", req}, "miss_req", 32'(miss_req), 32'd1);
    chk({"R5 ", req}, "miss_seg", 32'(miss_seg), 32'(s));
    chk({"R5 ", req}, "req_ready low", 32'(req_ready), 32'd0);
    fill_valid = 1'b1; fill_base = b; fill_len = l; fill_rights = r; fill_present = p;
    @(negedge clk);
    fill_valid = 1'b0;
    chk("R6", "no response yet", 32'(resp_valid), 32'd0);
    @(negedge clk);
    chk("R6", "replay response", 32'(resp_valid), 32'd1);
    chk("R6", "ready again", 32'(req_ready), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_seg = '0; req_disp = '0; req_acc = '0;
    fill_valid = 1'b0; fill_base = '0; fill_len = '0; fill_rights = '0;
    fill_present = 1'b0; flush = 1'b0; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "reset ready", 32'(req_ready), 32'd1);
    chk("R5", "reset miss_req", 32'(miss_req), 32'd0);
    chk("R1", "reset resp_valid", 32'(resp_valid), 32'd0);
    chk("R10", "reset lookup_cnt", 32'(lookup_cnt), 32'd0);

    // fill four empty slots (R7)
    look_miss(6'd5, 12'h010, 3'b001, 16'h1000, 13'h100, 3'b111, 1'b1, 2'd0, 16'h1010, "R6 seg5");
    look_hit (6'd5, 12'h020, 3'b001, 2'd0, 16'h1020, "R1 seg5");
    look_hit (6'd5, 12'h100, 3'b001, 2'd1, 16'h0000, "R2 len edge");
    look_hit (6'd5, 12'h0FF, 3'b010, 2'd0, 16'h10FF, "R2 last byte");
    look_miss(6'd9, 12'h000, 3'b001, 16'h2000, 13'h080, 3'b001, 1'b1, 2'd0, 16'h2000, "R6 seg9");
    look_hit (6'd9, 12'h004, 3'b010, 2'd1, 16'h0000, "R3 write denied");
    look_hit (6'd9, 12'h07F, 3'b001, 2'd0, 16'h207F, "R3 read allowed");
    look_miss(6'd12, 12'h000, 3'b001, 16'h5000, 13'h040, 3'b111, 1'b0, 2'd2, 16'h0000, "R4 seg12 absent");
    look_miss(6'd20, 12'h001, 3'b100, 16'h3000, 13'h040, 3'b101, 1'b1, 2'd0, 16'h3001, "R6 seg20");
    look_hit (6'd5, 12'h000, 3'b001, 2'd0, 16'h1000, "R7 seg5 kept");
    look_hit (6'd9, 12'h000, 3'b001, 2'd0, 16'h2000, "R7 seg9 kept");
    look_hit (6'd20, 12'h03F, 3'b100, 2'd0, 16'h303F, "R3 exec allowed");
    // full, all flags set: sweep clears all, takes slot 0 (seg5)
    look_miss(6'd33, 12'h002, 3'b001, 16'h4000, 13'h040, 3'b111, 1'b1, 2'd0, 16'h4002, "R8 seg33");
    // seg5 evicted; next victim slot 1 (seg9)
    look_miss(6'd5, 12'h003, 3'b001, 16'h1000, 13'h100, 3'b111, 1'b1, 2'd0, 16'h1003, "R8 seg5 evicted");
    look_hit (6'd12, 12'h000, 3'b001, 2'd2, 16'h0000, "R4 fault kept");
    // seg9 evicted; sweep passes slot 2 (seg12), takes slot 3 (seg20)
    look_miss(6'd9, 12'h001, 3'b001, 16'h2000, 13'h080, 3'b001, 1'b1, 2'd0, 16'h2001, "R8 seg9 evicted");
    look_hit (6'd12, 12'h000, 3'b001, 2'd2, 16'h0000, "R8 passed slot kept");
    look_miss(6'd20, 12'h002, 3'b001, 16'h3000, 13'h040, 3'b101, 1'b1, 2'd0, 16'h3002, "R8 seg20 evicted");
    @(negedge clk);
    chk("R10", "lookup_cnt", 32'(lookup_cnt), 32'd18);
    chk("R10", "hit_cnt", 32'(hit_cnt), 32'd10);

    // flush (R9)
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    look_miss(6'd5, 12'h004, 3'b001, 16'h1000, 13'h100, 3'b111, 1'b1, 2'd0, 16'h1004, "R9 after flush");
    look_miss(6'd12, 12'h000, 3'b001, 16'h6000, 13'h040, 3'b111, 1'b1, 2'd0, 16'h6000, "R9 seg12 after flush");

    // clear (R12)
    @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    chk("R12", "lookup_cnt cleared", 32'(lookup_cnt), 32'd0);
    chk("R12", "hit_cnt cleared", 32'(hit_cnt), 32'd0);

    // saturation (R11)
    for (int i = 0; i < 260; i++) begin
      look_hit(6'd5, 12'h001, 3'b001, 2'd0, 16'h1001, "R11 stream");
    end
    @(negedge clk);
    chk("R11", "lookup_cnt saturated", 32'(lookup_cnt), 32'd255);
    chk("R11", "hit_cnt saturated", 32'(hit_cnt), 32'd255);
    chk("R6", "scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule